// File: doc/BRIEF.md
# Code Memory Lock Guard

This block keeps three one-time lock bits for a small controller's on-chip code memory and turns them into the protection controls used by the core and the programming port. A lock bit can be set by a request and only power-on clears it, which stands for a fresh device. A hardware reset never clears it. The programmed bits give a protection level that only rises. Level 1 stops table reads that run from external code from reading internal code bytes. It also blocks code writes from the programming port and freezes the external-access strap at its value during reset. Level 2 also refuses verify reads. Level 3 also refuses execution from external memory.

The lock bits cannot be read at any port. Software and programmers can only see their effect. A refused table read or verify read returns a fixed fill byte, 00H by default, and never the stored code byte. The external-access level the core uses follows the pin while no lock is set. Once lock bit 1 (or any higher bit) is set, that level comes from a latch loaded on every clock edge where reset is high. A separate flag shows whether that latch has been loaded since power-on.

Top module: `lockguard_top`

## Requirements
- R1: After power-on (por_n low) with no lock programmed, code writes and verify reads are granted. Table reads return code_byte. ext_fetch_block is 0. ea_level follows ea_pin in the same cycle.
- R2: A lock_prog_req with lock_prog_idx 1, 2 or 3 sets lock bit 1, 2 or 3 at the next clock edge, at any protection level. Index 0 changes nothing. rst never clears a lock bit and only por_n low clears it.
- R3: The protection level is the number of the highest lock bit that is set, or 0 when none is set. Lower bits need not be set, so bit 3 alone gives level 3.
- R4: At level 1 or above, a table read (tbl_req=1) aimed at internal code (tbl_internal=1) while fetching from external memory (fetch_ext=1) sets tbl_blocked=1 and returns 00H on tbl_byte. In every other case tbl_byte equals code_byte and tbl_blocked=0.
- R5: pgm_wr_grant equals pgm_wr_req at level 0 and is 0 at level 1 or above.
- R6: pgm_rd_grant equals pgm_rd_req at level 0 or 1 and is 0 at level 2 or 3. verify_byte is code_byte when the read is granted and 00H otherwise.
- R7: ext_fetch_block is 1 exactly when fetch_ext=1 at level 3.
- R8: At level 1 or above, ea_level is the ea_pin value sampled at the last clock edge where rst was 1, and does not follow the live pin.
- R9: After por_n low, ea_known is 0 and the latched value reads 1. Both hold until a clock edge with rst=1 loads the pin value and sets ea_known to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on clear, active low, asynchronous; clears the lock bits and the strap latch |
| rst | input | 1 | Hardware reset, active high; loads the strap latch |
| ea_pin | input | 1 | External-access strap pin level |
| fetch_ext | input | 1 | Core is currently fetching from external code memory |
| lock_prog_req | input | 1 | Request to program one lock bit |
| lock_prog_idx | input | 2 | Lock bit number to program (1..3; 0 = none) |
| pgm_wr_req | input | 1 | Programming-port code write request |
| pgm_rd_req | input | 1 | Programming-port verify read request |
| tbl_req | input | 1 | Core table-read request |
| tbl_internal | input | 1 | Table-read address falls in internal code memory |
| code_byte | input | DATA_W | Byte read from internal code memory |
| ea_level | output | 1 | External-access level seen by the core |
| ea_known | output | 1 | Strap latch loaded since power-on |
| pgm_wr_grant | output | 1 | Code write allowed |
| pgm_rd_grant | output | 1 | Verify read allowed |
| verify_byte | output | DATA_W | Verify read data (fill when refused) |
| tbl_byte | output | DATA_W | Table-read data to the core (fill when blocked) |
| tbl_blocked | output | 1 | Current table read was refused |
| ext_fetch_block | output | 1 | Current external fetch is refused |

## Verification
The bench walks the lock bits up one at a time: 1, then 1+2, then 1+2+3. At each level it applies the same set of requests, so each step can be told apart from the previous level only by the one control that changes. Table reads are tried with all four combinations of fetch source and target. This shows the block depends on both conditions and not on either one alone. A second power-on followed by programming bit 3 alone separates highest-bit decoding from a count of the bits that are set. Toggling the strap pin across reset pulses, with and without lock bit 1, separates the live path from the latched path.

// File: rtl/lockguard_pkg.sv
package lockguard_pkg;

   // protection level, ordered so that a larger value is stronger
   typedef enum logic [1:0] {
      LVL_OPEN    = 2'd0,
      LVL_SEALED  = 2'd1,
      LVL_NOVRFY  = 2'd2,
      LVL_NOEXEC  = 2'd3
   } prot_lvl_e;

   // controls handed from the level decoder to the access gate
   typedef struct packed {
      logic wr_ok;       // code writes allowed
      logic rd_ok;       // verify reads allowed
      logic tbl_deny;    // external table reads of internal code refused
      logic xexec_deny;  // external execution refused
      logic use_latch;   // strap taken from reset latch
   } guard_ctl_t;

endpackage

// File: rtl/lg_lock_store.sv
module lg_lock_store #(
   parameter int NBITS = 3,
   localparam int IDX_W = $clog2(NBITS + 1)
) (
   input  logic             clk,
   input  logic             por_n,
   input  logic             set_req,
   input  logic [IDX_W-1:0] set_idx,
   output logic [NBITS-1:0] bits_o
);

   // one sticky flop per lock bit; only power-on clears it
   for (genvar i = 0; i < NBITS; i++) begin : g_bit
      always_ff @(posedge clk or negedge por_n) begin
         if (!por_n)
            bits_o[i] <= 1'b0;
         else if (set_req && (set_idx == IDX_W'(i + 1)))
            bits_o[i] <= 1'b1;
      end
   end

endmodule

// File: rtl/lg_level_decode.sv
module lg_level_decode
   import lockguard_pkg::*;
#(
   parameter int NBITS = 3
) (
   input  logic [NBITS-1:0] bits_i,
   output guard_ctl_t       ctl_o
);

   localparam int LVL_W = $bits(prot_lvl_e);

   logic [LVL_W-1:0] hi;
   prot_lvl_e        lvl;

   // highest programmed bit decides the level
   always_comb begin
      hi = '0;
      for (int i = 0; i < NBITS; i++)
         if (bits_i[i]) hi = LVL_W'(i + 1);
      lvl = prot_lvl_e'(hi);
   end

   always_comb begin
      ctl_o.wr_ok      = (lvl == LVL_OPEN);
      ctl_o.rd_ok      = (lvl <  LVL_NOVRFY);
      ctl_o.tbl_deny   = (lvl >= LVL_SEALED);
      ctl_o.xexec_deny = (lvl == LVL_NOEXEC);
      ctl_o.use_latch  = (lvl != LVL_OPEN);
   end

endmodule

// File: rtl/lg_ea_hold.sv
module lg_ea_hold (
   input  logic clk,
   input  logic por_n,
   input  logic rst,
   input  logic ea_pin,
   output logic latched_o,
   output logic known_o
);

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         latched_o <= 1'b1;
         known_o   <= 1'b0;
      end else if (rst) begin
         latched_o <= ea_pin;
         known_o   <= 1'b1;
      end
   end

endmodule

// File: rtl/lg_access_gate.sv
module lg_access_gate
   import lockguard_pkg::*;
#(
   parameter int                DATA_W = 8,
   parameter logic [DATA_W-1:0] FILL   = '0
) (
   input  guard_ctl_t        ctl_i,
   input  logic              fetch_ext,
   input  logic              pgm_wr_req,
   input  logic              pgm_rd_req,
   input  logic              tbl_req,
   input  logic              tbl_internal,
   input  logic [DATA_W-1:0] code_byte,
   output logic              pgm_wr_grant,
   output logic              pgm_rd_grant,
   output logic [DATA_W-1:0] verify_byte,
   output logic [DATA_W-1:0] tbl_byte,
   output logic              tbl_blocked,
   output logic              ext_fetch_block
);

   always_comb begin
      pgm_wr_grant    = pgm_wr_req & ctl_i.wr_ok;
      pgm_rd_grant    = pgm_rd_req & ctl_i.rd_ok;
      verify_byte     = pgm_rd_grant ? code_byte : FILL;
      tbl_blocked     = tbl_req & tbl_internal & fetch_ext & ctl_i.tbl_deny;
      tbl_byte        = tbl_blocked ? FILL : code_byte;
      ext_fetch_block = fetch_ext & ctl_i.xexec_deny;
   end

endmodule

// File: rtl/lockguard_top.sv
module lockguard_top
   import lockguard_pkg::*;
#(
   parameter int                DATA_W    = 8,
   parameter int                LOCK_BITS = 3,
   parameter logic [DATA_W-1:0] FILL      = '0,
   localparam int               IDX_W     = $clog2(LOCK_BITS + 1)
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              rst,
   input  logic              ea_pin,
   input  logic              fetch_ext,
   input  logic              lock_prog_req,
   input  logic [IDX_W-1:0]  lock_prog_idx,
   input  logic              pgm_wr_req,
   input  logic              pgm_rd_req,
   input  logic              tbl_req,
   input  logic              tbl_internal,
   input  logic [DATA_W-1:0] code_byte,
   output logic              ea_level,
   output logic              ea_known,
   output logic              pgm_wr_grant,
   output logic              pgm_rd_grant,
   output logic [DATA_W-1:0] verify_byte,
   output logic [DATA_W-1:0] tbl_byte,
   output logic              tbl_blocked,
   output logic              ext_fetch_block
);

   if (LOCK_BITS != 3) begin : g_bad_bits
      $error("lockguard_top: LOCK_BITS must be 3 to match the level encoding");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("lockguard_top: DATA_W must be at least 1");
   end

   logic [LOCK_BITS-1:0] lock_bits;
   guard_ctl_t           ctl;
   logic                 ea_latched;

   lg_lock_store #(.NBITS(LOCK_BITS)) u_store (
      .clk     (clk),
      .por_n   (por_n),
      .set_req (lock_prog_req),
      .set_idx (lock_prog_idx),
      .bits_o  (lock_bits)
   );

   lg_level_decode #(.NBITS(LOCK_BITS)) u_decode (
      .bits_i (lock_bits),
      .ctl_o  (ctl)
   );

   lg_ea_hold u_ea (
      .clk       (clk),
      .por_n     (por_n),
      .rst       (rst),
      .ea_pin    (ea_pin),
      .latched_o (ea_latched),
      .known_o   (ea_known)
   );

   lg_access_gate #(.DATA_W(DATA_W), .FILL(FILL)) u_gate (
      .ctl_i           (ctl),
      .fetch_ext       (fetch_ext),
      .pgm_wr_req      (pgm_wr_req),
      .pgm_rd_req      (pgm_rd_req),
      .tbl_req         (tbl_req),
      .tbl_internal    (tbl_internal),
      .code_byte       (code_byte),
      .pgm_wr_grant    (pgm_wr_grant),
      .pgm_rd_grant    (pgm_rd_grant),
      .verify_byte     (verify_byte),
      .tbl_byte        (tbl_byte),
      .tbl_blocked     (tbl_blocked),
      .ext_fetch_block (ext_fetch_block)
   );

   assign ea_level = ctl.use_latch ? ea_latched : ea_pin;

endmodule

// File: rtl/lg_guard_chk.sv
module lg_guard_chk #(
   parameter int                DATA_W = 8,
   parameter logic [DATA_W-1:0] FILL   = '0
) (
   input logic              clk,
   input logic              por_n,
   input logic              rst,
   input logic [2:0]        lock_bits,
   input logic              fetch_ext,
   input logic              tbl_internal,
   input logic              pgm_rd_req,
   input logic              ea_level,
   input logic              ea_known,
   input logic              pgm_wr_grant,
   input logic              pgm_rd_grant,
   input logic [DATA_W-1:0] verify_byte,
   input logic [DATA_W-1:0] tbl_byte,
   input logic              tbl_blocked,
   input logic              ext_fetch_block
);

   assert_lock_sticky_R2: assert property (@(posedge clk) disable iff (!por_n)
      (($past(lock_bits) & ~lock_bits) == 3'b000));

   assert_tbl_fill_R4: assert property (@(posedge clk) disable iff (!por_n)
      tbl_blocked |-> (tbl_byte == FILL) && fetch_ext && tbl_internal && (lock_bits != 3'b000));

   assert_wr_open_R5: assert property (@(posedge clk) disable iff (!por_n)
      pgm_wr_grant |-> (lock_bits == 3'b000));

   assert_rd_level_R6: assert property (@(posedge clk) disable iff (!por_n)
      pgm_rd_grant |-> (lock_bits[2:1] == 2'b00));

   assert_rd_fill_R6: assert property (@(posedge clk) disable iff (!por_n)
      (pgm_rd_req && !pgm_rd_grant) |-> (verify_byte == FILL));

   assert_xexec_R7: assert property (@(posedge clk) disable iff (!por_n)
      ext_fetch_block |-> fetch_ext && lock_bits[2]);

   assert_ea_frozen_R8: assert property (@(posedge clk) disable iff (!por_n)
      (lock_bits[0] && $past(lock_bits[0]) && !$past(rst)) |-> $stable(ea_level));

   assert_known_rise_R9: assert property (@(posedge clk) disable iff (!por_n)
      $rose(ea_known) |-> $past(rst));

endmodule

bind lockguard_top lg_guard_chk #(.DATA_W(DATA_W), .FILL(FILL)) u_chk (
   .clk             (clk),
   .por_n           (por_n),
   .rst             (rst),
   .lock_bits       (lock_bits),
   .fetch_ext       (fetch_ext),
   .tbl_internal    (tbl_internal),
   .pgm_rd_req      (pgm_rd_req),
   .ea_level        (ea_level),
   .ea_known        (ea_known),
   .pgm_wr_grant    (pgm_wr_grant),
   .pgm_rd_grant    (pgm_rd_grant),
   .verify_byte     (verify_byte),
   .tbl_byte        (tbl_byte),
   .tbl_blocked     (tbl_blocked),
   .ext_fetch_block (ext_fetch_block)
);

// File: tb/tb_lockguard_top.sv
module tb_lockguard_top;

   localparam int DW = 8;

   logic          clk = 1'b0;
   logic          por_n = 1'b0, rst = 1'b0, ea_pin = 1'b0, fetch_ext = 1'b0;
   logic          lock_prog_req = 1'b0;
   logic [1:0]    lock_prog_idx = 2'd0;
   logic          pgm_wr_req = 1'b0, pgm_rd_req = 1'b0, tbl_req = 1'b0, tbl_internal = 1'b0;
   logic [DW-1:0] code_byte = '0;
   logic          ea_level, ea_known, pgm_wr_grant, pgm_rd_grant, tbl_blocked, ext_fetch_block;
   logic [DW-1:0] verify_byte, tbl_byte;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #4 clk = ~clk;

   lockguard_top #(.DATA_W(DW)) dut (
      .clk, .por_n, .rst, .ea_pin, .fetch_ext, .lock_prog_req, .lock_prog_idx,
      .pgm_wr_req, .pgm_rd_req, .tbl_req, .tbl_internal, .code_byte,
      .ea_level, .ea_known, .pgm_wr_grant, .pgm_rd_grant, .verify_byte,
      .tbl_byte, .tbl_blocked, .ext_fetch_block
   );

   typedef struct {
      string         tag;
      logic          ea_l, ea_k, wr_g, rd_g, t_blk, x_blk;
      logic [DW-1:0] v_byte, t_byte;
   } exp_t;

   exp_t q[$];

   // requirement model state
   logic [2:0] m_bits  = 3'b000;
   logic       m_lat   = 1'b1;
   logic       m_known = 1'b0;

   task automatic chk(input string tag, input string fld, input logic [DW-1:0] got, input logic [DW-1:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s %s: got %0h expected %0h", tag, fld, got, exp);
      end
   endtask

   // monitor: compare at the falling edge, inputs were driven 2 ns after the rising edge
   always @(negedge clk) begin
      if (q.size() > 0) begin
         exp_t e;
         e = q.pop_front();
         chk(e.tag, "ea_level",        DW'(ea_level),        DW'(e.ea_l));
         chk(e.tag, "ea_known",        DW'(ea_known),        DW'(e.ea_k));
         chk(e.tag, "pgm_wr_grant",    DW'(pgm_wr_grant),    DW'(e.wr_g));
         chk(e.tag, "pgm_rd_grant",    DW'(pgm_rd_grant),    DW'(e.rd_g));
         chk(e.tag, "verify_byte",     verify_byte,          e.v_byte);
         chk(e.tag, "tbl_blocked",     DW'(tbl_blocked),     DW'(e.t_blk));
         chk(e.tag, "tbl_byte",        tbl_byte,             e.t_byte);
         chk(e.tag, "ext_fetch_block", DW'(ext_fetch_block), DW'(e.x_blk));
      end
   end

   // driver: drive one cycle of inputs, push what the requirements predict
   task automatic step(input string tag, input logic pr, input logic rs, input logic pin,
                       input logic fx, input logic lreq, input logic [1:0] lidx,
                       input logic wr, input logic rd, input logic tr, input logic ti,
                       input logic [DW-1:0] cb);
      exp_t e;
      int   lvl;
      @(posedge clk);
      #2;
      por_n = pr; rst = rs; ea_pin = pin; fetch_ext = fx;
      lock_prog_req = lreq; lock_prog_idx = lidx;
      pgm_wr_req = wr; pgm_rd_req = rd; tbl_req = tr; tbl_internal = ti; code_byte = cb;
      if (!pr) begin
         m_bits = 3'b000; m_lat = 1'b1; m_known = 1'b0;
      end
      lvl = m_bits[2] ? 3 : m_bits[1] ? 2 : m_bits[0] ? 1 : 0;   // R3 highest bit
      e.tag    = tag;
      e.ea_l   = (lvl >= 1) ? m_lat : pin;                       // R1, R8
      e.ea_k   = m_known;                                        // R9
      e.wr_g   = wr && (lvl == 0);                               // R5
      e.rd_g   = rd && (lvl < 2);                                // R6
      e.v_byte = e.rd_g ? cb : 8'h00;
      e.t_blk  = tr && ti && fx && (lvl >= 1);                   // R4
      e.t_byte = e.t_blk ? 8'h00 : cb;
      e.x_blk  = fx && (lvl == 3);                               // R7
      q.push_back(e);
      if (pr) begin
         if (lreq && lidx != 2'd0) m_bits[lidx - 2'd1] = 1'b1;   // R2
         if (rs) begin m_lat = pin; m_known = 1'b1; end
      end
   endtask

   initial begin
      // power-on and open state (R1, R9)
      step("R1_por",      0, 0, 0, 0, 0, 0, 1, 1, 0, 0, 8'h3C);
      step("R1_por",      0, 0, 1, 1, 0, 0, 0, 0, 1, 1, 8'h5A);
      step("R9_unknown",  1, 0, 0, 1, 0, 0, 1, 1, 1, 1, 8'hA5);
      step("R1_live_ea",  1, 0, 1, 1, 0, 0, 1, 1, 1, 1, 8'h77);
      step("R1_live_ea",  1, 0, 0, 0, 0, 0, 0, 1, 1, 1, 8'h19);
      step("R9_load",     1, 1, 1, 0, 0, 0, 0, 0, 0, 0, 8'h00);
      step("R9_known",    1, 0, 0, 1, 0, 0, 1, 0, 1, 0, 8'hE1);
      // index 0 changes nothing (R2)
      step("R2_idx0",     1, 0, 0, 1, 1, 0, 0, 0, 0, 0, 8'h11);
      step("R2_idx0",     1, 0, 1, 1, 0, 0, 1, 1, 1, 1, 8'h22);
      // level 1
      step("R2_set1",     1, 0, 0, 0, 1, 1, 0, 0, 0, 0, 8'h00);
      step("R8_latched",  1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 8'h00);
      step("R4_ext_int",  1, 0, 0, 1, 0, 0, 0, 0, 1, 1, 8'hC3);
      step("R4_int_int",  1, 0, 0, 0, 0, 0, 0, 0, 1, 1, 8'hC4);
      step("R4_ext_ext",  1, 0, 0, 1, 0, 0, 0, 0, 1, 0, 8'hC5);
      step("R4_noreq",    1, 0, 0, 1, 0, 0, 0, 0, 0, 1, 8'hC6);
      step("R5_wr_deny",  1, 0, 1, 0, 0, 0, 1, 1, 0, 0, 8'h6E);
      step("R2_rst_keep", 1, 1, 0, 0, 0, 0, 0, 0, 0, 0, 8'h00);
      step("R8_relatch",  1, 0, 1, 0, 0, 0, 1, 1, 0, 0, 8'h4D);
      step("R8_relatch",  1, 0, 1, 1, 0, 0, 0, 0, 1, 1, 8'h4E);
      // level 2
      step("R2_set2",     1, 0, 1, 0, 1, 2, 0, 0, 0, 0, 8'h00);
      step("R6_rd_deny",  1, 0, 1, 0, 0, 0, 1, 1, 0, 0, 8'h99);
      step("R6_rd_deny",  1, 0, 0, 1, 0, 0, 0, 1, 1, 1, 8'h9A);
      step("R7_no_xblk",  1, 0, 0, 1, 0, 0, 0, 0, 0, 0, 8'h00);
      // level 3
      step("R2_set3",     1, 0, 0, 0, 1, 3, 0, 0, 0, 0, 8'h00);
      step("R7_xblk",     1, 0, 0, 1, 0, 0, 1, 1, 1, 1, 8'hF0);
      step("R7_int",      1, 0, 0, 0, 0, 0, 0, 1, 1, 1, 8'hF1);
      step("R8_level3",   1, 1, 1, 0, 0, 0, 0, 0, 0, 0, 8'h00);
      step("R8_level3",   1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 8'h00);
      // second power-on, then bit 3 alone (R3)
      step("R9_por2",     0, 0, 0, 0, 0, 0, 1, 1, 0, 0, 8'h12);
      step("R1_open2",    1, 0, 1, 1, 0, 0, 1, 1, 1, 1, 8'h34);
      step("R3_bit3",     1, 0, 0, 0, 1, 3, 0, 0, 0, 0, 8'h00);
      step("R3_bit3",     1, 0, 0, 1, 0, 0, 1, 1, 1, 1, 8'h56);
      step("R9_unk_lat",  1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 8'h00);
      step("R9_load2",    1, 1, 0, 0, 0, 0, 0, 0, 0, 0, 8'h00);
      step("R8_bit3",     1, 0, 1, 0, 0, 0, 0, 0, 0, 0, 8'h00);
      step("R3_bit1add",  1, 0, 1, 0, 1, 1, 0, 0, 0, 0, 8'h00);
      step("R3_still3",   1, 0, 1, 1, 0, 0, 1, 1, 1, 1, 8'h78);
      repeat (3) @(posedge clk);
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: got hang expected completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule